// File: doc/BRIEF.md
# Programmable Auxiliary Clock Divider

This block divides an auxiliary clock by a programmable ratio. Software controls it through one 32-bit configuration word on a small write/read bus with byte enables. The word holds an enable flag and a 6-bit ratio field named `DIV`. While the divider is enabled, it produces a registered divided clock whose period is `DIV + 1` input cycles. It also produces a one-cycle strobe that marks the start of each output period. A consumer can use either the clock-shaped signal or the strobe as a clock enable.

The configuration word guards itself in two ways. First, the ratio field can only be rewritten while the divider is already running. The enable value held before a write decides this, so a write that turns the divider on loads only the enable flag. Second, any write with fewer than all four byte lanes active is dropped without a response. A new ratio waits for the current output period to finish, so no period is ever cut short. While the divider is off, both outputs stay low and the counter sits at zero.

Top module: `aux_clk_div`

## Requirements
- R1: After a synchronous reset, the configuration word reads 0x0000_0000 and both `div_clk` and `div_tick` are low.
- R2: The word layout is: enable at bit 31 and `DIV` at bits 21:16, with every other bit reading zero whatever was written to it. Read data appears on `rd_data` in the cycle after `rd_en` is sampled.
- R3: A write whose `wr_be` is not 4'b1111 leaves the whole word unchanged, and the divider keeps running as before.
- R4: The `DIV` field is loaded only when the enable bit was already 1 before the write. A write that sets enable and carries a ratio loads only the enable bit, and `DIV` keeps its last value while the divider is off.
- R5: While the enable bit is 0, `div_clk` and `div_tick` stay low, starting from the cycle after the disabling write takes effect.
- R6: While enabled, `div_tick` pulses for one cycle every `DIV + 1` input cycles, and `div_clk` is high in each cycle where `div_tick` is high.
- R7: In each period of N = `DIV + 1` cycles, `div_clk` is high for ceil(N/2) cycles and then low for floor(N/2) cycles. With `DIV = 0` it is therefore high in every cycle.
- R8: A new `DIV` written mid-period takes effect at the next period boundary. The running period completes with its old length.
- R9: After the enable bit becomes 1, the first period starts one cycle later with `div_tick` and `div_clk` high, and the count begins from zero.
- R10: Disabling and then re-enabling the divider restarts a full period from zero, rather than resuming the old phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Auxiliary input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| div_clk | output | 1 | Registered divided clock |
| div_tick | output | 1 | One-cycle strobe at the start of each output period |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a running period. The only way to observe it is that the current period keeps its old length and the next one takes the new length. The bench handles this by aligning to a `div_tick` at a falling edge and issuing the ratio write in that same cycle. It then counts cycles until the next strobe and expects the old length, and measures the following period for the new length. The enable-before-write rule is reached with a single write that turns the divider on and carries a ratio, followed by a read that must show the old ratio.

// File: rtl/aux_div_pkg.sv
package aux_div_pkg;
  localparam int unsigned AD_REG_W   = 32;
  localparam int unsigned AD_DIV_W   = 6;
  localparam int unsigned AD_DIV_LSB = 16;
  localparam int unsigned AD_EN_BIT  = 31;

  // Output drive decision for one cycle of the divider.
  typedef struct packed {
    logic clk_hi;
    logic tick;
  } ad_out_t;
endpackage

// File: rtl/aux_div_cfg_reg.sv
module aux_div_cfg_reg
  import aux_div_pkg::*;
#(
  parameter int unsigned REG_W   = AD_REG_W,
  parameter int unsigned DIV_W   = AD_DIV_W,
  parameter int unsigned DIV_LSB = AD_DIV_LSB,
  parameter int unsigned EN_BIT  = AD_EN_BIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [REG_W-1:0]   rd_data,
  output logic               cfg_en,
  output logic [DIV_W-1:0]   cfg_div
);
  localparam int unsigned BE_W = REG_W / 8;
  localparam logic [REG_W-1:0] EN_MASK  = REG_W'(1) << EN_BIT;
  localparam logic [REG_W-1:0] DIV_MASK = ((REG_W'(1) << DIV_W) - REG_W'(1)) << DIV_LSB;

  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;
  logic             full_word;

  // Only a write that drives every byte lane may touch the word.
  assign full_word = wr_en && (wr_be == {BE_W{1'b1}});

  // The ratio field follows the bus only when the enable held before
  // this write is set; reserved bits are masked to zero on every load.
  always_comb begin
    word_d = word_q;
    if (full_word) begin
      word_d = (wr_data & EN_MASK)
             | ((cfg_en ? wr_data : word_q) & DIV_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      rd_data <= '0;
    end else begin
      word_q <= word_d;
      if (rd_en) begin
        rd_data <= word_q;
      end
    end
  end

  assign cfg_en  = word_q[EN_BIT];
  assign cfg_div = word_q[DIV_LSB +: DIV_W];
endmodule

// File: rtl/aux_div_duty.sv
module aux_div_duty
  import aux_div_pkg::*;
#(
  parameter int unsigned DIV_W = AD_DIV_W
) (
  input  logic             wrap,
  input  logic [DIV_W-1:0] act_div,
  input  logic [DIV_W-1:0] nxt_cnt,
  output ad_out_t          drive
);
  localparam int unsigned HW = DIV_W + 1;

  logic [HW-1:0] high_len;

  // The high phase is ceil((act_div + 1) / 2) cycles long.
  assign high_len = (HW'(act_div) + HW'(2)) >> 1;

  always_comb begin
    if (wrap) begin
      drive.clk_hi = 1'b1;
      drive.tick   = 1'b1;
    end else begin
      drive.clk_hi = HW'(nxt_cnt) < high_len;
      drive.tick   = 1'b0;
    end
  end
endmodule

// File: rtl/aux_div_counter.sv
module aux_div_counter
  import aux_div_pkg::*;
#(
  parameter int unsigned DIV_W = AD_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_in,
  output logic             div_clk,
  output logic             div_tick
);
  logic             run_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;
  logic [DIV_W-1:0] nxt_cnt;
  logic             wrap;
  ad_out_t          drive;

  // A period ends when the count reaches the ratio latched at its start.
  assign wrap    = !run_q || (cnt_q == act_q);
  assign nxt_cnt = cnt_q + DIV_W'(1);

  aux_div_duty #(.DIV_W(DIV_W)) u_duty (
    .wrap    (wrap),
    .act_div (act_q),
    .nxt_cnt (nxt_cnt),
    .drive   (drive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      act_q    <= '0;
      div_clk  <= 1'b0;
      div_tick <= 1'b0;
    end else if (!enable) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      div_clk  <= 1'b0;
      div_tick <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      div_clk  <= drive.clk_hi;
      div_tick <= drive.tick;
      if (wrap) begin
        cnt_q <= '0;
        act_q <= div_in;
      end else begin
        cnt_q <= nxt_cnt;
      end
    end
  end
endmodule

// File: rtl/aux_clk_div.sv
module aux_clk_div
  import aux_div_pkg::*;
#(
  parameter int unsigned REG_W   = AD_REG_W,
  parameter int unsigned DIV_W   = AD_DIV_W,
  parameter int unsigned DIV_LSB = AD_DIV_LSB,
  parameter int unsigned EN_BIT  = AD_EN_BIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [REG_W-1:0]   rd_data,
  output logic               div_clk,
  output logic               div_tick
);
  logic             cfg_en;
  logic [DIV_W-1:0] cfg_div;

  aux_div_cfg_reg #(
    .REG_W   (REG_W),
    .DIV_W   (DIV_W),
    .DIV_LSB (DIV_LSB),
    .EN_BIT  (EN_BIT)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .cfg_en  (cfg_en),
    .cfg_div (cfg_div)
  );

  aux_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_en),
    .div_in   (cfg_div),
    .div_clk  (div_clk),
    .div_tick (div_tick)
  );
endmodule

// File: rtl/aux_clk_div_chk.sv
module aux_clk_div_chk #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DIV_LSB = 16,
  parameter int unsigned EN_BIT  = 31
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_W/8-1:0] wr_be,
  input logic [REG_W-1:0]   rd_data,
  input logic               cfg_en,
  input logic [DIV_W-1:0]   cfg_div,
  input logic               div_clk,
  input logic               div_tick
);
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << EN_BIT) | ((((REG_W'(1) << DIV_W) - REG_W'(1))) << DIV_LSB);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0);

  assert_narrow_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be != '1) |=> ($stable(cfg_en) && $stable(cfg_div)));

  assert_div_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cfg_en) |=> $stable(cfg_div));

  assert_quiet_off_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!div_clk && !div_tick));

  assert_tick_high_R6: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> div_clk);
endmodule

module aux_div_counter_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] act_q,
  input logic             div_tick
);
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_q);

  assert_mid_period_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(act_q));

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt_q == '0 && !div_tick));
endmodule

bind aux_clk_div aux_clk_div_chk #(
  .REG_W   (REG_W),
  .DIV_W   (DIV_W),
  .DIV_LSB (DIV_LSB),
  .EN_BIT  (EN_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_be    (wr_be),
  .rd_data  (rd_data),
  .cfg_en   (cfg_en),
  .cfg_div  (cfg_div),
  .div_clk  (div_clk),
  .div_tick (div_tick)
);

bind aux_div_counter aux_div_counter_chk #(.DIV_W(DIV_W)) u_cnt_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .cnt_q    (cnt_q),
  .act_q    (act_q),
  .div_tick (div_tick)
);

// File: tb/aux_clk_div_bench.sv
module aux_clk_div_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        div_clk;
  logic        div_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  aux_clk_div u_aux_clk_div (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .div_clk  (div_clk),
    .div_tick (div_tick)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_data = data; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic read_expect(input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic sync_tick();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!div_tick && guard < 300);
  endtask

  // Measure one full period from a tick: length and high cycles.
  task automatic measure(input int exp_len, input int exp_hi, input string req);
    int len = 1;
    int hi;
    sync_tick();
    hi = div_clk ? 1 : 0;
    forever begin
      @(negedge clk);
      if (div_tick || len > 300) break;
      len++;
      if (div_clk) hi++;
    end
    check(len == exp_len, {req, " period"}, len, exp_len);
    check(hi == exp_hi, {req, " high"}, hi, exp_hi);
  endtask

  task automatic t_reset();
    check(div_clk == 1'b0 && div_tick == 1'b0, "R1 outputs low", {div_clk, div_tick}, 0);
    read_expect(32'h0, "R1 reset word");
  endtask

  task automatic t_enable_load();
    bus_write(32'h8005_0000, 4'hF);
    read_expect(32'h8000_0000, "R4 enable write ignores DIV");
    bus_write(32'hFFC5_FFFF, 4'hF);
    read_expect(32'h8005_0000, "R2 layout and reserved zero");
  endtask

  task automatic t_ratios();
    measure(6, 3, "R6 DIV=5");
    bus_write(32'h8000_0000, 4'hF);
    measure(1, 1, "R7 DIV=0");
    bus_write(32'h8001_0000, 4'hF);
    measure(2, 1, "R7 DIV=1");
    bus_write(32'h8002_0000, 4'hF);
    measure(3, 2, "R7 DIV=2 odd");
    bus_write(32'h803F_0000, 4'hF);
    measure(64, 32, "R6 DIV=63");
  endtask

  task automatic t_narrow();
    logic [3:0] bes [4] = '{4'h1, 4'h3, 4'hC, 4'h7};
    bus_write(32'h8004_0000, 4'hF);
    foreach (bes[i]) begin
      bus_write(32'h0000_0000, bes[i]);
      read_expect(32'h8004_0000, "R3 narrow write dropped");
    end
    measure(5, 3, "R3 divider unaffected");
  endtask

  task automatic t_mid_change();
    int len = 1;
    bus_write(32'h8009_0000, 4'hF);
    sync_tick();
    sync_tick();
    wr_en = 1'b1; wr_data = 32'h8003_0000; wr_be = 4'hF;
    forever begin
      @(negedge clk);
      wr_en = 1'b0; wr_be = 4'h0;
      if (div_tick || len > 300) break;
      len++;
    end
    check(len == 10, "R8 old period completes", len, 10);
    measure(4, 2, "R8 new ratio next period");
  endtask

  task automatic t_disable();
    int hits = 0;
    bus_write(32'h0003_0000, 4'hF);
    @(negedge clk);
    check(div_clk == 1'b0 && div_tick == 1'b0, "R5 off after disable", {div_clk, div_tick}, 0);
    bus_write(32'h003F_0000, 4'hF);
    read_expect(32'h0003_0000, "R4 DIV locked while off");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (div_clk || div_tick) hits++;
    end
    check(hits == 0, "R5 stays low", hits, 0);
  endtask

  task automatic t_reenable();
    bus_write(32'h8000_0000, 4'hF);
    check(div_clk == 1'b0, "R9 not yet started", div_clk, 0);
    @(negedge clk);
    check(div_tick == 1'b1 && div_clk == 1'b1, "R9 first period start", {div_clk, div_tick}, 2'b11);
    measure(4, 2, "R10 fresh period");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_load();
    t_ratios();
    t_narrow();
    t_mid_change();
    t_disable();
    t_reenable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule